// File: doc/BRIEF.md
# Sectioned Snapshot Log Buffer

This block sits between one report-producing peripheral and a shared log collector. The peripheral presents a complete multi-word report on a wide parallel bus with a one-cycle strobe, and the block stores the whole report in that same cycle. Storage is organised as a ring of sections. Each section is split into subsections, and each subsection holds exactly one report, so a report never straddles a section boundary. Total storage in bytes is 4 × sections × subsections × report words.

Once a section has every subsection filled, the block raises a request toward the collector and holds it. When the collector grants the port, the block streams the section out as 32-bit words, one per clock, with a valid strobe. While an older full section waits or drains, new reports keep landing in the next free section. A report that arrives when every section is full is dropped and counted. A sticky flag and a saturating counter record these drops until a clear pulse.

Top module: `log_section_proxy`

## Requirements
- R1: After reset, `sec_ready`, `out_valid`, `ovf_flag` and `ovf_count` are all 0, and every section is empty.
- R2: A report presented with `snap_valid` high while a free subsection exists is stored whole in that cycle. When its section is later drained, its words leave in storage order: subsection 0 first, and inside a report the word in bits [31:0] first, then [63:32], and so on.
- R3: `sec_ready` stays low while the only stored reports fill part of a section. It rises in the cycle after the edge that stores the last subsection of a section.
- R4: `sec_ready` stays high until `grant` is sampled high with it. From the next cycle, `out_valid` is high for exactly N_SUBSEC × REPORT_WORDS consecutive cycles, with one word on `out_word` per cycle.
- R5: `grant` has no effect while `sec_ready` is low, and none during a drain before its last word. No extra words appear and no section is consumed.
- R6: `sec_ready` is low in the cycle that carries the last word of a section, unless another complete section is already waiting, in which case it stays high.
- R7: Sections form a circular queue. Reports captured during a drain go into the next free section, and reports across all sections leave in arrival order.
- R8: A report arriving when all N_SEC sections are full is discarded without disturbing stored data, and `ovf_flag` goes high and stays high until `ovf_clr`.
- R9: `ovf_count` adds one per discarded report and holds at its all-ones value instead of wrapping.
- R10: A pulse on `ovf_clr` zeroes `ovf_flag` and `ovf_count`. If a report is discarded in the same cycle, the flag ends at 1 and the count at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| snap_valid | input | 1 | Report strobe from the peripheral |
| snap_data | input | REPORT_WORDS×32 | Whole report; word k in bits [32k+31:32k] |
| grant | input | 1 | Collector permission to drain this port |
| ovf_clr | input | 1 | Clears the drop flag and drop counter |
| sec_ready | output | 1 | A complete section is waiting to be sent |
| out_valid | output | 1 | `out_word` carries a drained word |
| out_word | output | 32 | Drained data word |
| ovf_flag | output | 1 | Sticky drop indication |
| ovf_count | output | OVF_CNT_W | Saturating count of dropped reports |

## Verification
The bench goes after the hand-off points of the ring.

- **Partial section:** a design that requests on a partly filled section would raise `sec_ready` after one report.
- **Last word:** a design that frees a section late or early would leave `sec_ready` high after the final beat, or drop it while a second section waits.
- **Stray grants:** grants while empty or mid-drain are issued. A design that honours them would emit extra beats or skip a section.
- **Drops and clear:** captures while the ring is full must leave stored data intact, so the scoreboard would see corrupted or reordered words otherwise. The counter is driven past its ceiling to catch wrap-around, and a clear that collides with a drop would lose that drop in a wrong design.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
   localparam int LSP_WORD_W = 32;

   // index width that never collapses to zero bits
   function automatic int lsp_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/lsp_snap_mem.sv
module lsp_snap_mem
   import lsp_pkg::*;
#(
   parameter int N_SEC        = 4,
   parameter int N_SUBSEC     = 2,
   parameter int REPORT_WORDS = 3,
   localparam int SNAP_W = REPORT_WORDS * LSP_WORD_W,
   localparam int SEC_W  = lsp_idx_w(N_SEC),
   localparam int SUB_W  = lsp_idx_w(N_SUBSEC),
   localparam int WRD_W  = lsp_idx_w(REPORT_WORDS)
) (
   input  logic                  clk,
   input  logic                  wr_en,
   input  logic [SEC_W-1:0]      wr_sec,
   input  logic [SUB_W-1:0]      wr_sub,
   input  logic [SNAP_W-1:0]     wr_data,
   input  logic [SEC_W-1:0]      rd_sec,
   input  logic [SUB_W-1:0]      rd_sub,
   input  logic [WRD_W-1:0]      rd_wrd,
   output logic [LSP_WORD_W-1:0] rd_word
);
   localparam int ENTRIES = N_SEC * N_SUBSEC;
   localparam int ENT_W   = lsp_idx_w(ENTRIES);

   logic [SNAP_W-1:0]     store [ENTRIES];
   logic [ENT_W-1:0]      wr_addr;
   logic [ENT_W-1:0]      rd_addr;
   logic [SNAP_W-1:0]     rd_snap;
   logic [LSP_WORD_W-1:0] rd_lanes [REPORT_WORDS];

   assign wr_addr = ENT_W'(wr_sec) * ENT_W'(N_SUBSEC) + ENT_W'(wr_sub);
   assign rd_addr = ENT_W'(rd_sec) * ENT_W'(N_SUBSEC) + ENT_W'(rd_sub);

   // whole-report write port: one entry per subsection
   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   assign rd_snap = store[rd_addr];

   for (genvar g = 0; g < REPORT_WORDS; g++) begin : g_lane
      assign rd_lanes[g] = rd_snap[g*LSP_WORD_W +: LSP_WORD_W];
   end

   assign rd_word = rd_lanes[rd_wrd];
endmodule

// File: rtl/lsp_sec_ctrl.sv
module lsp_sec_ctrl
   import lsp_pkg::*;
#(
   parameter int N_SEC    = 4,
   parameter int N_SUBSEC = 2,
   localparam int SEC_W = lsp_idx_w(N_SEC),
   localparam int SUB_W = lsp_idx_w(N_SUBSEC),
   localparam int CNT_W = $clog2(N_SEC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_req,
   input  logic             sec_freed,
   output logic             cap_accept,
   output logic             cap_drop,
   output logic [SEC_W-1:0] wr_sec,
   output logic [SUB_W-1:0] wr_sub,
   output logic [CNT_W-1:0] full_cnt
);
   logic ring_full;
   logic sec_done;

   assign ring_full  = (full_cnt == CNT_W'(N_SEC));
   assign cap_accept = cap_req && !ring_full;
   assign cap_drop   = cap_req && ring_full;
   assign sec_done   = cap_accept && (wr_sub == SUB_W'(N_SUBSEC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_sec <= '0;
         wr_sub <= '0;
      end else if (cap_accept) begin
         if (sec_done) begin
            wr_sub <= '0;
            wr_sec <= (wr_sec == SEC_W'(N_SEC - 1)) ? '0 : wr_sec + 1'b1;
         end else begin
            wr_sub <= wr_sub + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     full_cnt <= '0;
      else if (sec_done && !sec_freed) full_cnt <= full_cnt + 1'b1;
      else if (!sec_done && sec_freed) full_cnt <= full_cnt - 1'b1;
   end

   AST_DROP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      cap_drop |=> ($stable(wr_sec) && $stable(wr_sub))); // R8
   AST_RING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      full_cnt <= CNT_W'(N_SEC)); // R7
   AST_NO_FREE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      sec_freed |-> (full_cnt != '0)); // R5
endmodule

// File: rtl/lsp_drain.sv
module lsp_drain
   import lsp_pkg::*;
#(
   parameter int N_SEC        = 4,
   parameter int N_SUBSEC     = 2,
   parameter int REPORT_WORDS = 3,
   localparam int SEC_W = lsp_idx_w(N_SEC),
   localparam int SUB_W = lsp_idx_w(N_SUBSEC),
   localparam int WRD_W = lsp_idx_w(REPORT_WORDS),
   localparam int CNT_W = $clog2(N_SEC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grant,
   input  logic [CNT_W-1:0] full_cnt,
   output logic             draining,
   output logic             last_beat,
   output logic             sec_ready,
   output logic [SEC_W-1:0] rd_sec,
   output logic [SUB_W-1:0] rd_sub,
   output logic [WRD_W-1:0] rd_wrd
);
   logic sub_end;
   logic wrd_end;
   logic start;

   assign wrd_end   = (rd_wrd == WRD_W'(REPORT_WORDS - 1));
   assign sub_end   = (rd_sub == SUB_W'(N_SUBSEC - 1));
   assign last_beat = draining && sub_end && wrd_end;
   assign sec_ready = last_beat ? (full_cnt > CNT_W'(1)) : (full_cnt != '0);
   assign start     = grant && sec_ready && (!draining || last_beat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         draining <= 1'b0;
         rd_sec   <= '0;
         rd_sub   <= '0;
         rd_wrd   <= '0;
      end else begin
         if (last_beat) begin
            rd_sec <= (rd_sec == SEC_W'(N_SEC - 1)) ? '0 : rd_sec + 1'b1;
         end
         if (start) begin
            draining <= 1'b1;
            rd_sub   <= '0;
            rd_wrd   <= '0;
         end else if (last_beat) begin
            draining <= 1'b0;
         end else if (draining) begin
            if (wrd_end) begin
               rd_wrd <= '0;
               rd_sub <= rd_sub + 1'b1;
            end else begin
               rd_wrd <= rd_wrd + 1'b1;
            end
         end
      end
   end

   AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && sec_ready && !draining) |=> draining); // R4
   AST_BEAT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      draining |-> (full_cnt != '0)); // R5
   AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (!draining && !sec_ready) |=> !draining); // R5
   AST_LAST_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat && full_cnt == CNT_W'(1)) |-> !sec_ready); // R6
endmodule

// File: rtl/lsp_ovf_track.sv
module lsp_ovf_track #(
   parameter int OVF_CNT_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 drop,
   input  logic                 clr,
   output logic                 ovf_flag,
   output logic [OVF_CNT_W-1:0] ovf_count
);
   localparam logic [OVF_CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag  <= 1'b0;
         ovf_count <= '0;
      end else if (clr) begin
         ovf_flag  <= drop;
         ovf_count <= drop ? OVF_CNT_W'(1) : '0;
      end else if (drop) begin
         ovf_flag <= 1'b1;
         if (ovf_count != CNT_MAX) ovf_count <= ovf_count + 1'b1;
      end
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !clr) |=> ovf_flag); // R8
   AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_count == CNT_MAX && !clr) |=> (ovf_count == CNT_MAX)); // R9
   AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !drop) |=> (!ovf_flag && ovf_count == '0)); // R10
endmodule

// File: rtl/log_section_proxy.sv
module log_section_proxy
   import lsp_pkg::*;
#(
   parameter int N_SEC        = 4,
   parameter int N_SUBSEC     = 2,
   parameter int REPORT_WORDS = 3,
   parameter int OVF_CNT_W    = 8,
   localparam int SNAP_W = REPORT_WORDS * LSP_WORD_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  snap_valid,
   input  logic [SNAP_W-1:0]     snap_data,
   input  logic                  grant,
   input  logic                  ovf_clr,
   output logic                  sec_ready,
   output logic                  out_valid,
   output logic [LSP_WORD_W-1:0] out_word,
   output logic                  ovf_flag,
   output logic [OVF_CNT_W-1:0]  ovf_count
);
   localparam int SEC_W = lsp_idx_w(N_SEC);
   localparam int SUB_W = lsp_idx_w(N_SUBSEC);
   localparam int WRD_W = lsp_idx_w(REPORT_WORDS);
   localparam int CNT_W = $clog2(N_SEC + 1);

   if (N_SEC < 2) begin : g_bad_sec
      $error("log_section_proxy: N_SEC must be at least 2");
   end
   if (N_SUBSEC < 1) begin : g_bad_sub
      $error("log_section_proxy: N_SUBSEC must be at least 1");
   end
   if (REPORT_WORDS < 1) begin : g_bad_wrd
      $error("log_section_proxy: REPORT_WORDS must be at least 1");
   end
   if (OVF_CNT_W < 1) begin : g_bad_cnt
      $error("log_section_proxy: OVF_CNT_W must be at least 1");
   end

   logic             cap_accept;
   logic             cap_drop;
   logic [SEC_W-1:0] wr_sec;
   logic [SUB_W-1:0] wr_sub;
   logic [CNT_W-1:0] full_cnt;
   logic             draining;
   logic             last_beat;
   logic [SEC_W-1:0] rd_sec;
   logic [SUB_W-1:0] rd_sub;
   logic [WRD_W-1:0] rd_wrd;

   lsp_sec_ctrl #(.N_SEC(N_SEC), .N_SUBSEC(N_SUBSEC)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_req    (snap_valid),
      .sec_freed  (last_beat),
      .cap_accept (cap_accept),
      .cap_drop   (cap_drop),
      .wr_sec     (wr_sec),
      .wr_sub     (wr_sub),
      .full_cnt   (full_cnt)
   );

   lsp_snap_mem #(.N_SEC(N_SEC), .N_SUBSEC(N_SUBSEC), .REPORT_WORDS(REPORT_WORDS)) u_mem (
      .clk     (clk),
      .wr_en   (cap_accept),
      .wr_sec  (wr_sec),
      .wr_sub  (wr_sub),
      .wr_data (snap_data),
      .rd_sec  (rd_sec),
      .rd_sub  (rd_sub),
      .rd_wrd  (rd_wrd),
      .rd_word (out_word)
   );

   lsp_drain #(.N_SEC(N_SEC), .N_SUBSEC(N_SUBSEC), .REPORT_WORDS(REPORT_WORDS)) u_drain (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant     (grant),
      .full_cnt  (full_cnt),
      .draining  (draining),
      .last_beat (last_beat),
      .sec_ready (sec_ready),
      .rd_sec    (rd_sec),
      .rd_sub    (rd_sub),
      .rd_wrd    (rd_wrd)
   );

   lsp_ovf_track #(.OVF_CNT_W(OVF_CNT_W)) u_ovf (
      .clk       (clk),
      .rst_n     (rst_n),
      .drop      (cap_drop),
      .clr       (ovf_clr),
      .ovf_flag  (ovf_flag),
      .ovf_count (ovf_count)
   );

   assign out_valid = draining;

   AST_NO_WRITE_ON_DRAIN_SEC: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_accept && draining) |-> (wr_sec != rd_sec)); // R7
   AST_DROP_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cap_drop |=> ovf_flag); // R8
endmodule

// File: tb/log_section_proxy_tb.sv
`timescale 1ns/1ps
module log_section_proxy_tb;
   localparam int NS  = 3;
   localparam int NSS = 2;
   localparam int RW  = 3;
   localparam int OW  = 3;
   localparam int SW  = NSS * RW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              snap_valid = 1'b0;
   logic [RW*32-1:0]  snap_data = '0;
   logic              grant = 1'b0;
   logic              ovf_clr = 1'b0;
   logic              sec_ready;
   logic              out_valid;
   logic [31:0]       out_word;
   logic              ovf_flag;
   logic [OW-1:0]     ovf_count;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q [$];
   int m_full = 0;
   int m_sub  = 0;
   int exp_cnt = 0;

   always #2 clk = ~clk;

   log_section_proxy #(.N_SEC(NS), .N_SUBSEC(NSS), .REPORT_WORDS(RW), .OVF_CNT_W(OW)) u_dut (
      .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid), .snap_data(snap_data),
      .grant(grant), .ovf_clr(ovf_clr), .sec_ready(sec_ready), .out_valid(out_valid),
      .out_word(out_word), .ovf_flag(ovf_flag), .ovf_count(ovf_count)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] word_of(input int id, input int k);
      return {8'(id), 8'(k), 16'hC0DE ^ 16'(id)};
   endfunction

   // driver: one report per call, scoreboard updated from the requirements
   task automatic push_snap(input int id);
      for (int k = 0; k < RW; k++) snap_data[k*32 +: 32] = word_of(id, k);
      snap_valid = 1'b1;
      if (m_full < NS) begin
         for (int k = 0; k < RW; k++) exp_q.push_back(word_of(id, k));
         m_sub++;
         if (m_sub == NSS) begin
            m_sub = 0;
            m_full++;
         end
      end else begin
         if (ovf_clr) exp_cnt = 1;
         else if (exp_cnt < (1 << OW) - 1) exp_cnt++;
      end
      @(negedge clk);
      snap_valid = 1'b0;
   endtask

   task automatic drain_one(input bit more, input bit mid_grant);
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      for (int k = 0; k < SW; k++) begin
         chk("R4 beat valid", 32'(out_valid), 32'd1);
         if (k == SW - 1) chk("R6 ready at last beat", 32'(sec_ready), 32'(more));
         if (mid_grant && k == 2) grant = 1'b1;
         if (k < SW - 1) begin
            @(negedge clk);
            grant = 1'b0;
         end
      end
      m_full--;
      @(negedge clk);
   endtask

   // monitor: pop and compare every drained word
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R2: actual %0h expected <none>", out_word);
         end else begin
            chk("R2 word order", out_word, exp_q.pop_front());
         end
      end
   end

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 sec_ready", 32'(sec_ready), 0);
      chk("R1 out_valid", 32'(out_valid), 0);
      chk("R1 ovf_flag", 32'(ovf_flag), 0);
      chk("R1 ovf_count", 32'(ovf_count), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: grant with nothing stored
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      chk("R5 empty grant", 32'(out_valid), 0);
      @(negedge clk);
      chk("R5 empty grant later", 32'(out_valid), 0);

      // R3: partial then full section
      push_snap(1);
      chk("R3 partial no ready", 32'(sec_ready), 0);
      push_snap(2);
      chk("R3 full ready", 32'(sec_ready), 1);
      repeat (3) @(negedge clk);
      chk("R4 ready held", 32'(sec_ready), 1);
      chk("R4 no beat before grant", 32'(out_valid), 0);

      // R5: stray grant mid-drain
      drain_one(1'b0, 1'b1);
      chk("R5 no extra beats", 32'(out_valid), 0);
      chk("R6 ready low after", 32'(sec_ready), 0);
      @(negedge clk);
      chk("R5 still idle", 32'(out_valid), 0);

      // R8: fill ring then drop one
      for (int i = 3; i <= 8; i++) push_snap(i);
      chk("R3 ring ready", 32'(sec_ready), 1);
      push_snap(9);
      chk("R8 flag set", 32'(ovf_flag), 1);
      chk("R9 count one", 32'(ovf_count), 32'(exp_cnt));

      drain_one(1'b1, 1'b0);
      // R7: write into freed section while another drains
      fork
         drain_one(1'b1, 1'b0);
         begin
            push_snap(10);
            push_snap(11);
         end
      join
      chk("R8 flag sticky", 32'(ovf_flag), 1);
      drain_one(1'b1, 1'b0);
      drain_one(1'b0, 1'b0);
      chk("R7 all words out", 32'(exp_q.size()), 0);

      // R9: saturation
      for (int i = 20; i <= 25; i++) push_snap(i);
      for (int i = 30; i < 38; i++) push_snap(i);
      chk("R9 saturated", 32'(ovf_count), 32'((1 << OW) - 1));
      chk("R9 model agrees", 32'(exp_cnt), 32'((1 << OW) - 1));

      // R10: clear alone, then clear colliding with a drop
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
      exp_cnt = 0;
      chk("R10 flag cleared", 32'(ovf_flag), 0);
      chk("R10 count cleared", 32'(ovf_count), 0);
      ovf_clr = 1'b1;
      push_snap(40);
      ovf_clr = 1'b0;
      chk("R10 collide flag", 32'(ovf_flag), 1);
      chk("R10 collide count", 32'(ovf_count), 1);

      drain_one(1'b1, 1'b0);
      drain_one(1'b1, 1'b0);
      drain_one(1'b0, 1'b0);
      chk("R7 queue empty", 32'(exp_q.size()), 0);
      chk("R6 idle ready", 32'(sec_ready), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule